// File: doc/BRIEF.md
# Masked fast GPIO port

A 32-bit general-purpose I/O port controller that sits on a simple synchronous register bus. Writes are single-cycle and carry per-byte write strobes. Reads are combinational from the current address. The controller holds three registers: a per-pin direction register, a mask register and an output latch. The latch drives the pins, and each pin's output driver is enabled only while its direction bit selects output.

Software changes the latch in one of three ways. A set write forces ones, a clear write forces zeros, and a port-value write loads a new value directly. The mask register gates all three kinds of write: a bit whose mask bit is 1 is frozen. Reads of the port-value register return the pin levels after a two-stage synchronizer, with masked bit positions returned as zero. Reads of the set and clear registers return the output latch.

Top module: `masked_gpio_port`

## Requirements
- R1: After reset the direction register, the mask register and the output latch are all zero, so pad_oe and pad_out are zero.
- R2: The direction register is at byte offset 0x00. Bit i at 1 makes pin i an output (pad_oe[i]=1); bit i at 0 makes it an input. The register reads back as written.
- R3: Every register write honours bus_be. Byte lane k (bits 8k+7..8k) is written only when bus_be[k] is 1; other lanes keep their value.
- R4: A write to the set register at offset 0x18 sets each latch bit whose data bit is 1, whose lane is strobed and whose mask bit is 0. All other latch bits keep their value.
- R5: A write to the clear register at offset 0x1C clears each latch bit whose data bit is 1, whose lane is strobed and whose mask bit is 0. All other latch bits keep their value.
- R6: A write to the port-value register at offset 0x14 loads the data into each latch bit that is strobed and unmasked.
- R7: The mask register is at offset 0x10 and reads back as written. A latch bit whose mask bit is 1 is unchanged by set, clear and port-value writes. Writes to the mask register itself are not gated by the mask.
- R8: A port-value read returns pad_in & ~mask. A pad_in value sampled at one rising edge becomes visible after the second rising edge, and not after the first.
- R9: Reads at offsets 0x18 and 0x1C return the output latch.
- R10: Offsets 0x04, 0x08 and 0x0C, and any address whose two low bits are not zero, read as zero. Writes to them change no register.
- R11: pad_out always equals the output latch, whatever the direction bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_be | input | 4 | Byte write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when no read is in progress |
| pad_in | input | 32 | Pin levels (asynchronous) |
| pad_out | output | 32 | Output latch to the pin drivers |
| pad_oe | output | 32 | Per-pin output driver enable |

## Verification
The bench sweeps all fifteen non-zero strobe patterns against every writable register under three masks: all clear, a fixed stripe and a pseudo-random value. The data comes from an arithmetic generator, and every register and pin output is compared with a bench model after each write. The clear mask separates plain set, clear and load behaviour from byte-lane gating. The two non-zero masks show whether a masked bit ever moves. Separate patterns on pad_in sample the port-value read one and two edges after a change, which separates the synchronizer depth from the read masking. Writes to holes in the address map confirm that no register changes.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int unsigned ADDR_W = 5;

    // Word index = byte offset / 4
    typedef enum logic [2:0] {
        IDX_DIR  = 3'd0,
        IDX_MASK = 3'd4,
        IDX_PORT = 3'd5,
        IDX_SET  = 3'd6,
        IDX_CLR  = 3'd7
    } reg_idx_e;

    function automatic logic idx_mapped(input logic [2:0] idx);
        return (idx == IDX_DIR) || (idx == IDX_MASK) || (idx == IDX_PORT)
            || (idx == IDX_SET) || (idx == IDX_CLR);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pin_sync
);

    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
        logic [1:0]       warm;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = pad_in;
        st_d.stage2 = st_q.stage1;
        st_d.warm   = (st_q.warm == 2'd2) ? 2'd2 : st_q.warm + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_sync = st_q.stage2;

    // R8: two edges of latency from pad to read path
    a_r8_sync_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.warm == 2'd2) |-> (pin_sync == $past(pad_in, 2)));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  reg_idx_e           wr_idx,
    input  logic [WIDTH/8-1:0] wr_be,
    input  logic [WIDTH-1:0]   wr_data,
    output logic [WIDTH-1:0]   dir_q,
    output logic [WIDTH-1:0]   mask_q,
    output logic [WIDTH-1:0]   latch_q
);

    localparam int unsigned LANES = WIDTH / 8;

    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] mask;
        logic [WIDTH-1:0] lat;
    } regs_t;

    regs_t r_d, r_q;
    logic [WIDTH-1:0] lane_bits;
    logic [WIDTH-1:0] lat_en;
    logic [WIDTH-1:0] dir_wbits;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bits[g*8 +: 8] = {8{wr_be[g]}};
    end

    assign lat_en    = lane_bits & ~r_q.mask;
    assign dir_wbits = (wr_en && wr_idx == IDX_DIR) ? lane_bits : '0;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_idx)
                IDX_DIR:  r_d.dir  = (r_q.dir  & ~lane_bits) | (wr_data & lane_bits);
                IDX_MASK: r_d.mask = (r_q.mask & ~lane_bits) | (wr_data & lane_bits);
                IDX_PORT: r_d.lat  = (r_q.lat  & ~lat_en)    | (wr_data & lat_en);
                IDX_SET:  r_d.lat  = r_q.lat | (wr_data & lat_en);
                IDX_CLR:  r_d.lat  = r_q.lat & ~(wr_data & lat_en);
                default:  r_d      = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dir_q   = r_q.dir;
    assign mask_q  = r_q.mask;
    assign latch_q = r_q.lat;

    // R1: reset clears everything
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (r_q == '0));

    // R3: direction bits move only in strobed lanes of a direction write
    a_r3_dir_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((r_q.dir ^ $past(r_q.dir)) & ~$past(dir_wbits)) == '0));

    // R4: set write leaves every enabled one-bit high
    a_r4_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_SET) |=>
        ((r_q.lat & $past(wr_data & lat_en)) == $past(wr_data & lat_en)));

    // R5: clear write leaves every enabled one-bit low
    a_r5_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_CLR) |=>
        ((r_q.lat & $past(wr_data & lat_en)) == '0));

    // R7: masked latch bits never move
    a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((r_q.lat ^ $past(r_q.lat)) & $past(r_q.mask)) == '0));

endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             rd_en,
    input  reg_idx_e         rd_idx,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] mask_q,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (rd_idx)
                IDX_DIR:          rdata = dir_q;
                IDX_MASK:         rdata = mask_q;
                IDX_PORT:         rdata = pin_sync & ~mask_q;
                IDX_SET, IDX_CLR: rdata = latch_q;
                default:          rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/masked_gpio_port.sv
module masked_gpio_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WIDTH/8-1:0] bus_be,
    input  logic [WIDTH-1:0]   bus_wdata,
    output logic [WIDTH-1:0]   bus_rdata,
    input  logic [WIDTH-1:0]   pad_in,
    output logic [WIDTH-1:0]   pad_out,
    output logic [WIDTH-1:0]   pad_oe
);

    reg_idx_e         idx;
    logic             hit;
    logic             wr_en;
    logic             rd_en;
    logic [WIDTH-1:0] dir_q, mask_q, latch_q, pin_sync;

    assign idx   = reg_idx_e'(bus_addr[ADDR_W-1:2]);
    assign hit   = (bus_addr[1:0] == 2'b00) && idx_mapped(bus_addr[ADDR_W-1:2]);
    assign wr_en = bus_sel && bus_wr && hit;
    assign rd_en = bus_sel && !bus_wr && hit;

    gpio_sync #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .pin_sync (pin_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (idx),
        .wr_be   (bus_be),
        .wr_data (bus_wdata),
        .dir_q   (dir_q),
        .mask_q  (mask_q),
        .latch_q (latch_q)
    );

    gpio_rdmux #(.WIDTH(WIDTH)) u_rdmux (
        .rd_en    (rd_en),
        .rd_idx   (idx),
        .dir_q    (dir_q),
        .mask_q   (mask_q),
        .latch_q  (latch_q),
        .pin_sync (pin_sync),
        .rdata    (bus_rdata)
    );

    assign pad_out = latch_q;
    assign pad_oe  = dir_q;

    // R10: a write to an unmapped hole changes no register
    a_r10_hole_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !hit) |=>
        ($stable(dir_q) && $stable(mask_q) && $stable(latch_q)));

endmodule

// File: tb/masked_gpio_port_test.sv
module masked_gpio_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_dir = '0, m_mask = '0, m_lat = '0;
    logic [31:0] rng = 32'h1234_5678;

    always #2 clk = ~clk;

    masked_gpio_port uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic [31:0] lanes(input logic [3:0] be);
        logic [31:0] v = '0;
        for (int k = 0; k < 4; k++) if (be[k]) v[k*8 +: 8] = 8'hFF;
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_be = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic model_wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
        logic [31:0] ln = lanes(be);
        logic [31:0] en = ln & ~m_mask;
        case (a)
            5'h00: m_dir  = (m_dir & ~ln) | (d & ln);
            5'h10: m_mask = (m_mask & ~ln) | (d & ln);
            5'h14: m_lat  = (m_lat & ~en) | (d & en);
            5'h18: m_lat  = m_lat | (d & en);
            5'h1C: m_lat  = m_lat & ~(d & en);
            default: ;
        endcase
    endtask

    task automatic verify_all(input string tag);
        logic [31:0] v;
        rd(5'h18, v); check({tag, " R9 set-read latch"}, v, m_lat);
        rd(5'h1C, v); check({tag, " R9 clr-read latch"}, v, m_lat);
        rd(5'h00, v); check({tag, " R2 dir readback"}, v, m_dir);
        rd(5'h10, v); check({tag, " R7 mask readback"}, v, m_mask);
        check({tag, " R11 pad_out"}, pad_out, m_lat);
        check({tag, " R2 pad_oe"}, pad_oe, m_dir);
    endtask

    initial begin
        logic [31:0] v, prev_lat;
        logic [4:0] ops [5];
        string names [5];
        ops[0] = 5'h00; ops[1] = 5'h10; ops[2] = 5'h14; ops[3] = 5'h18; ops[4] = 5'h1C;
        names[0] = "R3 dir"; names[1] = "R3 mask"; names[2] = "R6 port";
        names[3] = "R4 set"; names[4] = "R5 clr";

        repeat (3) @(negedge clk);
        rd(5'h00, v); check("R1 dir reset", v, 32'h0);
        rd(5'h10, v); check("R1 mask reset", v, 32'h0);
        rd(5'h18, v); check("R1 latch reset", v, 32'h0);
        check("R1 pad_oe reset", pad_oe, 32'h0);
        check("R1 pad_out reset", pad_out, 32'h0);
        rst_n = 1'b1;

        for (int pass = 0; pass < 3; pass++) begin
            logic [31:0] mv;
            rng = rng * 32'd1664525 + 32'd1013904223;
            mv = (pass == 0) ? 32'h0 : (pass == 1) ? 32'h00FF_00F0 : rng;
            wr(5'h10, 4'hF, mv); model_wr(5'h10, 4'hF, mv);
            verify_all("mask setup");
            for (int be = 1; be < 16; be++) begin
                for (int op = 0; op < 5; op++) begin
                    rng = rng * 32'd1664525 + 32'd1013904223;
                    if (op == 1) continue;
                    prev_lat = m_lat;
                    wr(ops[op], be[3:0], rng);
                    model_wr(ops[op], be[3:0], rng);
                    verify_all(names[op]);
                    check("R7 masked bits frozen", (pad_out ^ prev_lat) & m_mask, 32'h0);
                end
                // mask lane write, then restore full mask value
                rng = rng * 32'd1664525 + 32'd1013904223;
                wr(5'h10, be[3:0], rng); model_wr(5'h10, be[3:0], rng);
                verify_all("R3 mask lanes");
                wr(5'h10, 4'hF, mv); model_wr(5'h10, 4'hF, mv);
            end
        end

        // R10 holes and misaligned addresses
        for (int h = 0; h < 6; h++) begin
            logic [4:0] ha;
            ha = (h < 3) ? 5'(4 * (h + 1)) : 5'(5'h14 + h - 2);
            wr(ha, 4'hF, 32'hFFFF_FFFF);
            rd(ha, v); check("R10 hole reads zero", v, 32'h0);
            verify_all("R10 hole write");
        end

        // R8 synchronizer depth and masking
        wr(5'h10, 4'hF, 32'h0000_FFFF); model_wr(5'h10, 4'hF, 32'h0000_FFFF);
        pad_in = 32'h0;
        repeat (3) @(negedge clk);
        for (int p = 0; p < 8; p++) begin
            logic [31:0] pv;
            rng = rng * 32'd1664525 + 32'd1013904223;
            pv = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h0 : (p == 2) ? 32'hA5A5_5A5A : rng;
            @(negedge clk);
            prev_lat = pad_in;
            pad_in = pv;
            @(negedge clk);
            rd(5'h14, v); check("R8 not visible after one edge", v, prev_lat & ~m_mask);
            @(negedge clk);
            rd(5'h14, v); check("R8 visible after two edges", v, pv & ~m_mask);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule